// File: doc/BRIEF.md
# I2C Event Status and Interrupt Flag Unit

This unit sits beside an I2C bus engine and turns its one-cycle event pulses into the status that software sees. The pulses cover a finished byte (one pulse after the eight data bits, one after the acknowledge slot), a calling-address match from any of several address sources, lost arbitration, SMBus timeouts, and start and stop detection. From these pulses the unit keeps one sticky interrupt-pending flag. It also holds two sticky bus-edge flags, the acknowledge level of the last transmitted byte, and the direction bit of the last matched calling address.

Software reads two byte-wide registers over a simple write/read port. Every sticky bit is cleared by writing 1 to it. The interrupt line is the pending flag gated by a global enable. The byte-complete source changes with the early-acknowledge setting: with it off, the flag sets after the acknowledge slot; with it on, the flag sets after the data bits. While a start or stop flag is still set and edge interrupts are enabled, the pending flag keeps coming back. Software must therefore clear the edge flag before it clears the pending flag.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset, both register bytes read 0x00 and `irq` is 0.
- R2: The pending flag (status register at address 0, bit 2) holds until a write to address 0 has bit 2 set. A write with bit 2 clear leaves it unchanged.
- R3: With `cfg_fast_ack` = 0, `ev_ack_done` sets the pending flag and `ev_data_done` does not. With `cfg_fast_ack` = 1 the roles swap.
- R4: A pulse on `ev_addr_hit[i]` sets the pending flag only when `cfg_addr_src_en[i]` = 1.
- R5: `ev_arb_lost` sets the pending flag.
- R6: A timeout sets the pending flag only when `cfg_smbus_en` = 1, and only for bit 0 of `ev_timeout` (low timeout). Bit 1 (clock-high timeout) and bit 2 (data-high timeout) never set it.
- R7: `ev_start` and `ev_stop` set sticky flags at address 1, bit 0 and bit 1. These are set whatever the enable, and each is cleared by writing 1 to its bit.
- R8: When `cfg_edge_irq_en` = 1, a start or stop pulse sets the pending flag. While either edge flag remains set, the pending flag sets again on every cycle. When `cfg_edge_irq_en` = 0, edge activity never sets it.
- R9: Status bit 0 takes the value of `ev_ack_level` on each `ev_ack_done` pulse (0 = acknowledge seen, 1 = none) and holds it otherwise.
- R10: Status bit 1 takes `ev_addr_rw` on each enabled address match (0 = master writes, 1 = master reads) and holds it otherwise.
- R11: `irq` equals the pending flag ANDed with `cfg_irq_en`.
- R12: When a set event and a write-one-to-clear of the same flag fall in the same cycle, the flag ends up set. Reads of any address other than 0 and 1 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fast_ack | input | 1 | Early-acknowledge mode: byte event taken after the data bits |
| cfg_edge_irq_en | input | 1 | Start/stop detection may raise the pending flag |
| cfg_smbus_en | input | 1 | SMBus mode, enables timeout events |
| cfg_irq_en | input | 1 | Global interrupt enable |
| cfg_addr_src_en | input | N_ADDR_SRC | Per-source address match enable |
| ev_data_done | input | 1 | Eight data bits finished |
| ev_ack_done | input | 1 | Acknowledge slot finished |
| ev_ack_level | input | 1 | Sampled acknowledge level, valid with ev_ack_done |
| ev_addr_hit | input | N_ADDR_SRC | Per-source calling-address match pulse |
| ev_addr_rw | input | 1 | Direction bit of the calling address |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_timeout | input | TMO_W | Timeout pulses: bit0 low, bit1 clock high, bit2 data high |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data (write-one-to-clear) |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the acknowledge-timing swap. A design that wires the wrong pulse would raise the flag one bus bit early or late, and would raise it twice or never. It tries clearing the pending flag while a start or stop flag is still set. A unit without the re-assert would drop the request and lose the edge interrupt. Clearing the edge flag first must then let the pending flag go. Same-cycle set and clear, masked address sources and the two high timeouts are driven on purpose. A unit that let clear win, or that ignored the masks, would show a missing or spurious pending bit. A long random run follows and compares every register byte and the interrupt line against a model after each cycle.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
   localparam int REG_DW    = 8;
   // status register bit positions
   localparam int ST_NACK   = 0;
   localparam int ST_SRD    = 1;
   localparam int ST_PEND   = 2;
   // edge register bit positions
   localparam int EF_START  = 0;
   localparam int EF_STOP   = 1;
   localparam int EF_W      = 2;
   // timeout vector bit positions
   localparam int TMO_LOW   = 0;
   localparam int TMO_CLKHI = 1;
   localparam int TMO_DATHI = 2;

   typedef struct packed {
      logic nack;
      logic srd;
   } cap_t;
endpackage

// File: rtl/i2c_evt_sticky.sv
module i2c_evt_sticky #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("i2c_evt_sticky: W must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_o[b] <= 1'b0;
         else
            q_o[b] <= set_i[b] | (q_o[b] & ~clr_i[b]);
      end
   end
endmodule

// File: rtl/i2c_evt_src.sv
module i2c_evt_src #(
   parameter int          N_SRC    = 5,
   parameter int          TMO_W    = 3,
   parameter logic [TMO_W-1:0] TMO_MASK = 3'b001,
   parameter bit          SMBUS    = 1'b1
) (
   input  logic             fast_ack_i,
   input  logic             edge_en_i,
   input  logic             smbus_en_i,
   input  logic [N_SRC-1:0] src_en_i,
   input  logic [N_SRC-1:0] hit_i,
   input  logic             data_done_i,
   input  logic             ack_done_i,
   input  logic             arb_lost_i,
   input  logic [TMO_W-1:0] timeout_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             start_q_i,
   input  logic             stop_q_i,
   output logic             hit_any_o,
   output logic             pend_set_o
);
   logic byte_evt;
   logic tmo_evt;
   logic edge_evt;

   // byte completion point follows the acknowledge mode
   assign byte_evt  = fast_ack_i ? data_done_i : ack_done_i;
   assign hit_any_o = |(hit_i & src_en_i);

   generate
      if (SMBUS) begin : g_tmo
         assign tmo_evt = smbus_en_i & |(timeout_i & TMO_MASK);
      end else begin : g_no_tmo
         logic unused_tmo;
         assign unused_tmo = smbus_en_i ^ (^timeout_i);
         assign tmo_evt    = 1'b0;
      end
   endgenerate

   // held edge flags keep requesting while enabled
   assign edge_evt = edge_en_i & (start_i | stop_i | start_q_i | stop_q_i);

   assign pend_set_o = byte_evt | hit_any_o | arb_lost_i | tmo_evt | edge_evt;
endmodule

// File: rtl/i2c_evt_regif.sv
module i2c_evt_regif
   import i2c_evt_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int EDGE_ADDR = 1
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_DW-1:0] wdata_i,
   input  logic              pend_i,
   input  cap_t              cap_i,
   input  logic [EF_W-1:0]   edge_i,
   output logic              pend_clr_o,
   output logic [EF_W-1:0]   edge_clr_o,
   output logic [REG_DW-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(EDGE_ADDR);

   generate
      if (STAT_ADDR == EDGE_ADDR) begin : g_bad_map
         $error("i2c_evt_regif: register addresses collide");
      end
      if (STAT_ADDR >= (1 << ADDR_W) || EDGE_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("i2c_evt_regif: address outside ADDR_W range");
      end
   endgenerate

   logic wr_stat;
   logic wr_edge;
   logic unused_wdata;

   assign wr_stat      = wr_i && (addr_i == A_STAT);
   assign wr_edge      = wr_i && (addr_i == A_EDGE);
   assign unused_wdata = ^wdata_i;

   assign pend_clr_o = wr_stat & wdata_i[ST_PEND];
   assign edge_clr_o = wr_edge ? wdata_i[EF_W-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_STAT) begin
         rdata_o[ST_NACK] = cap_i.nack;
         rdata_o[ST_SRD]  = cap_i.srd;
         rdata_o[ST_PEND] = pend_i;
      end else if (addr_i == A_EDGE) begin
         rdata_o[EF_START] = edge_i[EF_START];
         rdata_o[EF_STOP]  = edge_i[EF_STOP];
      end
   end
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
   import i2c_evt_pkg::*;
#(
   parameter int               N_ADDR_SRC = 5,
   parameter int               TMO_W      = 3,
   parameter logic [TMO_W-1:0] TMO_MASK   = 3'b001,
   parameter bit               SMBUS      = 1'b1,
   parameter int               ADDR_W     = 2,
   parameter int               STAT_ADDR  = 0,
   parameter int               EDGE_ADDR  = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_fast_ack,
   input  logic                  cfg_edge_irq_en,
   input  logic                  cfg_smbus_en,
   input  logic                  cfg_irq_en,
   input  logic [N_ADDR_SRC-1:0] cfg_addr_src_en,
   input  logic                  ev_data_done,
   input  logic                  ev_ack_done,
   input  logic                  ev_ack_level,
   input  logic [N_ADDR_SRC-1:0] ev_addr_hit,
   input  logic                  ev_addr_rw,
   input  logic                  ev_arb_lost,
   input  logic [TMO_W-1:0]      ev_timeout,
   input  logic                  ev_start,
   input  logic                  ev_stop,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [REG_DW-1:0]     reg_wdata,
   output logic [REG_DW-1:0]     reg_rdata,
   output logic                  irq
);
   generate
      if (N_ADDR_SRC < 1 || N_ADDR_SRC > 16) begin : g_bad_src
         $error("i2c_evt_status: N_ADDR_SRC out of range");
      end
      if (TMO_W < 1 || TMO_W > 8) begin : g_bad_tmo
         $error("i2c_evt_status: TMO_W out of range");
      end
   endgenerate

   logic            pend_q;
   logic            pend_set;
   logic            pend_clr;
   logic            hit_any;
   logic            start_q;
   logic            stop_q;
   logic [EF_W-1:0] edge_q;
   logic [EF_W-1:0] edge_set;
   logic [EF_W-1:0] edge_clr;
   cap_t            cap_q;

   assign start_q = edge_q[EF_START];
   assign stop_q  = edge_q[EF_STOP];

   always_comb begin
      edge_set           = '0;
      edge_set[EF_START] = ev_start;
      edge_set[EF_STOP]  = ev_stop;
   end

   i2c_evt_src #(
      .N_SRC    (N_ADDR_SRC),
      .TMO_W    (TMO_W),
      .TMO_MASK (TMO_MASK),
      .SMBUS    (SMBUS)
   ) u_src (
      .fast_ack_i  (cfg_fast_ack),
      .edge_en_i   (cfg_edge_irq_en),
      .smbus_en_i  (cfg_smbus_en),
      .src_en_i    (cfg_addr_src_en),
      .hit_i       (ev_addr_hit),
      .data_done_i (ev_data_done),
      .ack_done_i  (ev_ack_done),
      .arb_lost_i  (ev_arb_lost),
      .timeout_i   (ev_timeout),
      .start_i     (ev_start),
      .stop_i      (ev_stop),
      .start_q_i   (start_q),
      .stop_q_i    (stop_q),
      .hit_any_o   (hit_any),
      .pend_set_o  (pend_set)
   );

   i2c_evt_sticky #(.W(1)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (pend_set),
      .clr_i (pend_clr),
      .q_o   (pend_q)
   );

   i2c_evt_sticky #(.W(EF_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (edge_set),
      .clr_i (edge_clr),
      .q_o   (edge_q)
   );

   // captured bus status: acknowledge level and calling direction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else begin
         if (ev_ack_done) cap_q.nack <= ev_ack_level;
         if (hit_any)     cap_q.srd  <= ev_addr_rw;
      end
   end

   i2c_evt_regif #(
      .ADDR_W    (ADDR_W),
      .STAT_ADDR (STAT_ADDR),
      .EDGE_ADDR (EDGE_ADDR)
   ) u_regif (
      .wr_i       (reg_wr),
      .addr_i     (reg_addr),
      .wdata_i    (reg_wdata),
      .pend_i     (pend_q),
      .cap_i      (cap_q),
      .edge_i     (edge_q),
      .pend_clr_o (pend_clr),
      .edge_clr_o (edge_clr),
      .rdata_o    (reg_rdata)
   );

   assign irq = pend_q & cfg_irq_en;
endmodule

// File: rtl/i2c_evt_status_chk.sv
module i2c_evt_status_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_fast_ack,
   input logic cfg_edge_irq_en,
   input logic cfg_irq_en,
   input logic ev_data_done,
   input logic ev_arb_lost,
   input logic ev_start,
   input logic ev_stop,
   input logic wr_stat,
   input logic wdata_pend,
   input logic irq,
   input logic pend_q,
   input logic start_q,
   input logic stop_q
);
   // R2: without a clearing write the pending flag holds
   a_r2_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !(wr_stat && wdata_pend) |=> pend_q);

   // R3: early-acknowledge byte event raises the flag
   a_r3_fast_byte: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fast_ack && ev_data_done |=> pend_q);

   // R12: a set event beats a same-cycle clear
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_arb_lost |=> pend_q);

   // R7: edge detections are captured
   a_r7_start_seen: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> start_q);
   a_r7_stop_seen: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> stop_q);

   // R8: a held edge flag keeps the pending flag up when enabled
   a_r8_reassert: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_edge_irq_en && (start_q || stop_q) |=> pend_q);

   // R11: the request never fires without enable and a pending flag
   a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cfg_irq_en && pend_q));
endmodule

bind i2c_evt_status i2c_evt_status_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_fast_ack    (cfg_fast_ack),
   .cfg_edge_irq_en (cfg_edge_irq_en),
   .cfg_irq_en      (cfg_irq_en),
   .ev_data_done    (ev_data_done),
   .ev_arb_lost     (ev_arb_lost),
   .ev_start        (ev_start),
   .ev_stop         (ev_stop),
   .wr_stat         (reg_wr && (reg_addr == ADDR_W'(STAT_ADDR))),
   .wdata_pend      (reg_wdata[2]),
   .irq             (irq),
   .pend_q          (pend_q),
   .start_q         (start_q),
   .stop_q          (stop_q)
);

// File: tb/i2c_evt_status_tb_top.sv
module i2c_evt_status_tb_top;
   localparam int NS = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_fast_ack = 0, cfg_edge_irq_en = 0, cfg_smbus_en = 0, cfg_irq_en = 0;
   logic [NS-1:0] cfg_addr_src_en = '0;
   logic ev_data_done = 0, ev_ack_done = 0, ev_ack_level = 0;
   logic [NS-1:0] ev_addr_hit = '0;
   logic ev_addr_rw = 0, ev_arb_lost = 0, ev_start = 0, ev_stop = 0;
   logic [2:0] ev_timeout = '0;
   logic reg_wr = 0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model state
   logic m_pend = 0, m_nack = 0, m_srd = 0, m_start = 0, m_stop = 0;

   always #5 clk = ~clk;

   i2c_evt_status dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_fast_ack(cfg_fast_ack), .cfg_edge_irq_en(cfg_edge_irq_en),
      .cfg_smbus_en(cfg_smbus_en), .cfg_irq_en(cfg_irq_en),
      .cfg_addr_src_en(cfg_addr_src_en),
      .ev_data_done(ev_data_done), .ev_ack_done(ev_ack_done),
      .ev_ack_level(ev_ack_level), .ev_addr_hit(ev_addr_hit),
      .ev_addr_rw(ev_addr_rw), .ev_arb_lost(ev_arb_lost),
      .ev_timeout(ev_timeout), .ev_start(ev_start), .ev_stop(ev_stop),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [7:0] exp_stat();
      return {5'b0, m_pend, m_srd, m_nack};
   endfunction

   function automatic logic [7:0] exp_edge();
      return {6'b0, m_stop, m_start};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_pend & cfg_irq_en});
      reg_addr = 2'd0; #1;
      chk({tag, " status"}, reg_rdata, exp_stat());
      reg_addr = 2'd1; #1;
      chk({tag, " edge"}, reg_rdata, exp_edge());
      reg_addr = 2'd2; #1;
      chk({tag, " unmapped"}, reg_rdata, 8'h00);
   endtask

   // apply the driven stimulus for one clock and compare afterwards
   task automatic step(input string tag);
      logic bc, hit, tmo, es, setp, clrp, n_pend, n_start, n_stop, n_nack, n_srd;
      bc   = cfg_fast_ack ? ev_data_done : ev_ack_done;
      hit  = |(ev_addr_hit & cfg_addr_src_en);
      tmo  = cfg_smbus_en & ev_timeout[0];
      es   = cfg_edge_irq_en & (ev_start | ev_stop | m_start | m_stop);
      setp = bc | hit | ev_arb_lost | tmo | es;
      clrp = reg_wr && reg_addr == 2'd0 && reg_wdata[2];
      n_pend  = setp | (m_pend & ~clrp);
      n_start = ev_start | (m_start & ~(reg_wr && reg_addr == 2'd1 && reg_wdata[0]));
      n_stop  = ev_stop  | (m_stop  & ~(reg_wr && reg_addr == 2'd1 && reg_wdata[1]));
      n_nack  = ev_ack_done ? ev_ack_level : m_nack;
      n_srd   = hit ? ev_addr_rw : m_srd;
      @(posedge clk); #1;
      m_pend = n_pend; m_start = n_start; m_stop = n_stop; m_nack = n_nack; m_srd = n_srd;
      ev_data_done = 0; ev_ack_done = 0; ev_addr_hit = '0; ev_arb_lost = 0;
      ev_timeout = '0; ev_start = 0; ev_stop = 0; reg_wr = 0; reg_wdata = '0;
      check_all(tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got hung expected finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      check_all("R1");
      cfg_irq_en = 1;
      // R5 and R2
      ev_arb_lost = 1; step("R5");
      wr(2'd0, 8'hFB); step("R2 zero-write");
      wr(2'd1, 8'h04); step("R2 other addr");
      wr(2'd0, 8'h04); step("R2 clear");
      // R3 and R9
      ev_data_done = 1; step("R3 slow data");
      ev_ack_done = 1; ev_ack_level = 1; step("R3 slow ack R9");
      wr(2'd0, 8'h04); step("R3");
      cfg_fast_ack = 1;
      ev_ack_done = 1; ev_ack_level = 0; step("R3 fast ack R9");
      ev_data_done = 1; step("R3 fast data");
      wr(2'd0, 8'h04); cfg_irq_en = 0; step("R11");
      cfg_irq_en = 1;
      // R4 and R10
      cfg_addr_src_en = 5'b00111;
      ev_addr_hit = 5'b01000; ev_addr_rw = 1; step("R4 masked R10");
      cfg_addr_src_en = 5'b01000;
      ev_addr_hit = 5'b01000; ev_addr_rw = 1; step("R4 enabled R10");
      wr(2'd0, 8'h04); step("R4");
      // R6
      ev_timeout = 3'b001; step("R6 smbus off");
      cfg_smbus_en = 1;
      ev_timeout = 3'b110; step("R6 high timeouts");
      ev_timeout = 3'b001; step("R6 low timeout");
      wr(2'd0, 8'h04); step("R6");
      // R7 and R8
      ev_start = 1; step("R7 start no-enable R8");
      wr(2'd1, 8'h01); step("R7 clear start");
      cfg_edge_irq_en = 1;
      ev_stop = 1; step("R8 stop");
      wr(2'd0, 8'h04); step("R8 reassert");
      wr(2'd1, 8'h02); step("R8 clear stop");
      wr(2'd0, 8'h04); step("R8 final clear");
      // R12
      ev_arb_lost = 1; wr(2'd0, 8'h04); step("R12 set wins");
      ev_start = 1; wr(2'd1, 8'h01); step("R12 edge set wins");
      wr(2'd1, 8'h03); step("R12");
      wr(2'd0, 8'h04); step("R12");
      // random mix
      for (int i = 0; i < 600; i++) begin
         if (($urandom % 16) == 0) begin
            cfg_fast_ack    = 1'($urandom);
            cfg_edge_irq_en = 1'($urandom);
            cfg_smbus_en    = 1'($urandom);
            cfg_irq_en      = 1'($urandom);
            cfg_addr_src_en = NS'($urandom);
         end
         ev_data_done = (($urandom % 8) == 0);
         ev_ack_done  = (($urandom % 8) == 0);
         ev_ack_level = 1'($urandom);
         ev_addr_hit  = (($urandom % 6) == 0) ? NS'($urandom) : '0;
         ev_addr_rw   = 1'($urandom);
         ev_arb_lost  = (($urandom % 12) == 0);
         ev_timeout   = (($urandom % 8) == 0) ? 3'($urandom) : 3'b0;
         ev_start     = (($urandom % 10) == 0);
         ev_stop      = (($urandom % 10) == 0);
         if (($urandom % 3) == 0) wr(2'($urandom), 8'($urandom));
         step("R12 random");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule